// File: doc/BRIEF.md
# Byte-Lane Load/Store Steering Unit

This unit sits between a 32-bit processor core and a 32-bit memory bus that only accepts whole-word addresses. The core issues a load or store at any byte address, with a size of byte, halfword or word. The unit turns that request into four things on the bus: an aligned word address, a byte-enable strobe per lane, and write data already placed in the enabled lanes. It also reports a misalignment error for multi-byte accesses that are not aligned. It works out everything on the request side combinationally, in the same cycle as the request.

A lane select input picks the byte order. When low, the order is big-endian, the default: byte offset 0 is the most significant lane. When high, the order is little-endian: offset 0 is the least significant lane. When a read is accepted, the unit stores its size, byte offset, order and signedness. It later uses that stored context to extract the addressed byte or halfword from the word the memory returns, and then zero-extends or sign-extends it to 32 bits.

Top module: `mem_lane_steer`

## Requirements
- R1: `bus_addr` equals `req_addr` with bits 1:0 forced to zero.
- R2: Size code 00 is a byte access. Strobe bit i covers data bits 8i+7:8i. In big-endian mode (`le_mode`=0), a byte at offset o enables only strobe bit 3-o. In little-endian mode, it enables only strobe bit o.
- R3: Size code 01 is a halfword access. In big-endian mode, offset 0 gives strobes 1100 and offset 2 gives 0011; little-endian mode swaps these two patterns. Size code 10 is a word access and gives strobes 1111.
- R4: A request raises `misalign_err` and drives strobes 0000 and `bus_req`=0 in any of these cases: size 01 with address bit 0 set; size 10 with nonzero address bits 1:0; size 11 at any address.
- R5: Without `req_valid`, strobes are 0000 and both `bus_req` and `misalign_err` are 0. With `req_valid`, `bus_req` is 1 exactly when the access is aligned.
- R6: For a store, each enabled lane of `bus_wdata` carries its byte as follows. A byte store places `req_wdata[7:0]` in the lane. A halfword store places `req_wdata[15:8]` in the odd lane and `req_wdata[7:0]` in the even lane. A word store places `req_wdata` unchanged. Lanes that are not enabled are zero, and `bus_wdata` is all zero for loads.
- R7: For a byte load, `rd_data` takes its low byte from the lane that R2 selected when the load was accepted.
- R8: For a halfword load, `rd_data` takes its low 16 bits from the lane pair that R3 selected. For a word load, `rd_data` equals `bus_rdata`.
- R9: When `req_signed`=1, byte and halfword loads fill the upper bits of `rd_data` with the top bit of the selected data. When `req_signed`=0, those upper bits are zero.
- R10: The read context changes only on a clock edge where an aligned load is requested. Stores, misaligned requests, idle cycles and changes of `le_mode` leave `rd_data` formatting unchanged.
- R11: After reset, the read context is an unsigned word, so `rd_data` equals `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| le_mode | input | 1 | 0 big-endian, 1 little-endian |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Byte-lane strobes |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_req | output | 1 | Aligned access issued |
| misalign_err | output | 1 | Misaligned or reserved-size request |
| bus_rdata | input | 32 | Word returned by memory |
| rd_data | output | 32 | Extended load result |

## Verification
The bench checks every byte offset and both halfword offsets in both byte orders. A design with the orders swapped, or with the halfword pair chosen wrongly, would enable the mirror-image strobes and pick the wrong lanes on reads. It also checks loads that are negative as bytes against positive ones, so that a design that always sign-extends or never does returns a wrong upper field. It sends halfword, word and reserved-size requests at misaligned addresses, where a faulty design would still assert strobes or `bus_req`. After an accepted byte load, it issues stores, misaligned loads and flips of the byte order. A design that reformatted read data from live inputs, instead of from the stored context, would change `rd_data` at that point.

// File: rtl/lane_pkg.sv
package lane_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   // Context captured when a load is accepted
   typedef struct packed {
      acc_size_e  size;
      logic [1:0] off;
      logic       le;
      logic       sgn;
   } rd_ctx_t;

endpackage

// File: rtl/lane_strobe_dec.sv
module lane_strobe_dec
   import lane_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic             valid,
   input  acc_size_e        size,
   input  logic [OFF_W-1:0] off,
   input  logic             le,
   output logic [LANES-1:0] be,
   output logic             err
);

   logic             bad;
   logic [OFF_W-1:0] lane_b;

   always_comb begin
      case (size)
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = off[0];
         SZ_WORD: bad = (off != '0);
         default: bad = 1'b1;
      endcase
   end

   assign lane_b = le ? off : (OFF_W'(LANES - 1) - off);
   assign err    = valid & bad;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic hit;
      always_comb begin
         case (size)
            SZ_BYTE: hit = (OFF_W'(i) == lane_b);
            SZ_HALF: hit = (OFF_W'(i) >> 1) == (lane_b >> 1);
            SZ_WORD: hit = 1'b1;
            default: hit = 1'b0;
         endcase
      end
      assign be[i] = valid & ~bad & hit;
   end

endmodule

// File: rtl/lane_wr_pack.sv
module lane_wr_pack
   import lane_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW = LANES * 8
) (
   input  logic             write,
   input  acc_size_e        size,
   input  logic [DW-1:0]    src,
   input  logic [LANES-1:0] be,
   output logic [DW-1:0]    dout
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] b;
      always_comb begin
         case (size)
            SZ_BYTE: b = src[7:0];
            SZ_HALF: b = src[8*(i%2) +: 8];
            default: b = src[8*i +: 8];
         endcase
      end
      assign dout[8*i +: 8] = (write & be[i]) ? b : 8'h00;
   end

endmodule

// File: rtl/lane_rd_unpack.sv
module lane_rd_unpack
   import lane_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DW = LANES * 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  rd_ctx_t       ctx,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] dout
);

   logic [OFF_W-1:0] lane_b;
   logic [OFF_W-2:0] pair;
   logic [7:0]       bsel;
   logic [15:0]      hsel;

   assign lane_b = ctx.le ? ctx.off : (OFF_W'(LANES - 1) - ctx.off);
   assign pair   = lane_b[OFF_W-1:1];
   assign bsel   = rdata[{lane_b, 3'b000} +: 8];
   assign hsel   = rdata[{pair, 4'b0000} +: 16];

   always_comb begin
      case (ctx.size)
         SZ_BYTE: dout = {{(DW-8){ctx.sgn & bsel[7]}}, bsel};
         SZ_HALF: dout = {{(DW-16){ctx.sgn & hsel[15]}}, hsel};
         default: dout = rdata;
      endcase
   end

endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
   import lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le_mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_req,
   output logic              misalign_err,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] rd_data
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_dw
      $error("mem_lane_steer: DATA_W must be 32");
   end
   if (ADDR_W < OFF_W + 1) begin : g_bad_aw
      $error("mem_lane_steer: ADDR_W too small");
   end

   acc_size_e size_e;
   logic      err;
   rd_ctx_t   ctx_q;

   assign size_e   = acc_size_e'(req_size);
   assign bus_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   lane_strobe_dec #(.LANES(LANES)) u_dec (
      .valid (req_valid),
      .size  (size_e),
      .off   (req_addr[OFF_W-1:0]),
      .le    (le_mode),
      .be    (bus_be),
      .err   (err)
   );

   assign misalign_err = err;
   assign bus_req      = req_valid & ~err;

   lane_wr_pack #(.LANES(LANES)) u_wr (
      .write (req_write),
      .size  (size_e),
      .src   (req_wdata),
      .be    (bus_be),
      .dout  (bus_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_q <= '{size: SZ_WORD, off: 2'b00, le: 1'b0, sgn: 1'b0};
      end else if (req_valid && !req_write && !err) begin
         ctx_q <= '{size: size_e, off: req_addr[1:0], le: le_mode, sgn: req_signed};
      end
   end

   lane_rd_unpack #(.LANES(LANES)) u_rd (
      .ctx   (ctx_q),
      .rdata (bus_rdata),
      .dout  (rd_data)
   );

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [1:0]  req_size,
   input logic [31:0] req_addr,
   input logic [31:0] bus_addr,
   input logic [3:0]  bus_be,
   input logic [31:0] bus_wdata,
   input logic        bus_req,
   input logic        misalign_err,
   input logic [31:0] bus_rdata,
   input logic [31:0] rd_data
);

   logic [31:0] lane_mask;
   for (genvar i = 0; i < 4; i++) begin : g_m
      assign lane_mask[8*i +: 8] = {8{bus_be[i]}};
   end

   // R1
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == {req_addr[31:2], 2'b00});

   // R2
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'b00) |-> $countones(bus_be) == 1);

   // R3
   word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'b10 && req_addr[1:0] == 2'b00) |-> bus_be == 4'hF);

   // R4
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> (bus_be == 4'h0 && !bus_req));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (bus_be == 4'h0 && !bus_req && !misalign_err));

   // R6
   wdata_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wdata & ~lane_mask) == 32'h0);

   // R10
   word_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && !req_write && req_size == 2'b10 && req_addr[1:0] == 2'b00)
      |-> rd_data == bus_rdata);

endmodule

bind mem_lane_steer lane_steer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_size     (req_size),
   .req_addr     (req_addr),
   .bus_addr     (bus_addr),
   .bus_be       (bus_be),
   .bus_wdata    (bus_wdata),
   .bus_req      (bus_req),
   .misalign_err (misalign_err),
   .bus_rdata    (bus_rdata),
   .rd_data      (rd_data)
);

// File: tb/sim_mem_lane_steer.sv
module sim_mem_lane_steer;

   localparam int PERIOD = 10;
   localparam logic [31:0] WD = 32'hA1B2C3D4;
   localparam logic [31:0] RD = 32'h80F17E22;
   localparam logic [31:0] BASE = 32'h1000_0000;

   typedef struct packed {
      logic        le;
      logic        wr;
      logic [1:0]  sz;
      logic        sgn;
      logic [1:0]  lo;
      logic        chk_rd;
      logic [3:0]  be;
      logic        err;
      logic [31:0] wd;
      logic [31:0] rd;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,2'b00,1'b0,2'd0,1'b1,4'b1000,1'b0,32'h0,32'h00000080},
      '{1'b0,1'b0,2'b00,1'b1,2'd0,1'b1,4'b1000,1'b0,32'h0,32'hFFFFFF80},
      '{1'b0,1'b0,2'b00,1'b1,2'd1,1'b1,4'b0100,1'b0,32'h0,32'hFFFFFFF1},
      '{1'b0,1'b0,2'b00,1'b1,2'd2,1'b1,4'b0010,1'b0,32'h0,32'h0000007E},
      '{1'b0,1'b0,2'b00,1'b0,2'd3,1'b1,4'b0001,1'b0,32'h0,32'h00000022},
      '{1'b1,1'b0,2'b00,1'b1,2'd0,1'b1,4'b0001,1'b0,32'h0,32'h00000022},
      '{1'b1,1'b0,2'b00,1'b1,2'd3,1'b1,4'b1000,1'b0,32'h0,32'hFFFFFF80},
      '{1'b0,1'b0,2'b01,1'b1,2'd0,1'b1,4'b1100,1'b0,32'h0,32'hFFFF80F1},
      '{1'b0,1'b0,2'b01,1'b0,2'd2,1'b1,4'b0011,1'b0,32'h0,32'h00007E22},
      '{1'b1,1'b0,2'b01,1'b1,2'd0,1'b1,4'b0011,1'b0,32'h0,32'h00007E22},
      '{1'b1,1'b0,2'b01,1'b0,2'd2,1'b1,4'b1100,1'b0,32'h0,32'h000080F1},
      '{1'b0,1'b0,2'b10,1'b1,2'd0,1'b1,4'b1111,1'b0,32'h0,32'h80F17E22},
      '{1'b0,1'b1,2'b00,1'b0,2'd1,1'b0,4'b0100,1'b0,32'h00D40000,32'h0},
      '{1'b1,1'b1,2'b00,1'b0,2'd1,1'b0,4'b0010,1'b0,32'h0000D400,32'h0},
      '{1'b0,1'b1,2'b01,1'b0,2'd2,1'b0,4'b0011,1'b0,32'h0000C3D4,32'h0},
      '{1'b1,1'b1,2'b01,1'b0,2'd2,1'b0,4'b1100,1'b0,32'hC3D40000,32'h0},
      '{1'b1,1'b1,2'b10,1'b0,2'd0,1'b0,4'b1111,1'b0,32'hA1B2C3D4,32'h0},
      '{1'b0,1'b0,2'b01,1'b0,2'd1,1'b0,4'b0000,1'b1,32'h0,32'h0},
      '{1'b0,1'b1,2'b10,1'b0,2'd2,1'b0,4'b0000,1'b1,32'h0,32'h0},
      '{1'b0,1'b0,2'b11,1'b0,2'd0,1'b0,4'b0000,1'b1,32'h0,32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        le_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [31:0] req_addr = 32'h0;
   logic [31:0] req_wdata = 32'h0;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic        bus_req;
   logic        misalign_err;
   logic [31:0] bus_rdata = 32'h0;
   logic [31:0] rd_data;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   mem_lane_steer u0 (
      .clk(clk), .rst_n(rst_n), .le_mode(le_mode), .req_valid(req_valid),
      .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
      .req_addr(req_addr), .req_wdata(req_wdata), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_req(bus_req),
      .misalign_err(misalign_err), .bus_rdata(bus_rdata), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic le, input logic wr, input logic [1:0] sz,
                        input logic sgn, input logic [31:0] addr);
      le_mode = le; req_write = wr; req_size = sz; req_signed = sgn;
      req_addr = addr; req_wdata = WD; req_valid = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      bus_rdata = 32'h5A6B7C8D;
      #1;
      // R11 reset context passes the word through
      check("R11 rd_data after reset", rd_data, 32'h5A6B7C8D);
      // R5 idle outputs
      check("R5 idle strobes/req/err", {27'h0, bus_be, bus_req, misalign_err}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k].le, VECS[k].wr, VECS[k].sz, VECS[k].sgn, BASE | {30'h0, VECS[k].lo});
         bus_rdata = 32'h0;
         #1;
         check($sformatf("R2 R3 R4 strobes v%0d", k), {28'h0, bus_be}, {28'h0, VECS[k].be});
         check($sformatf("R4 error flag v%0d", k), {31'h0, misalign_err}, {31'h0, VECS[k].err});
         check($sformatf("R5 bus_req v%0d", k), {31'h0, bus_req}, {31'h0, ~VECS[k].err});
         check($sformatf("R1 address v%0d", k), bus_addr, BASE);
         check($sformatf("R6 write data v%0d", k), bus_wdata, VECS[k].wd);
         @(negedge clk);
         req_valid = 1'b0;
         bus_rdata = RD;
         #1;
         if (VECS[k].chk_rd)
            check($sformatf("R7 R8 R9 load result v%0d", k), rd_data, VECS[k].rd);
      end

      // R1 high address bits pass, low bits cleared
      @(negedge clk);
      drive(1'b0, 1'b0, 2'b00, 1'b0, 32'hDEADBEEF);
      #1;
      check("R1 address DEADBEEF", bus_addr, 32'hDEADBEEC);

      // R10 context held across non-accepting requests: accepted BE byte offset 0 unsigned
      @(negedge clk);
      drive(1'b0, 1'b0, 2'b00, 1'b0, BASE);
      @(negedge clk);
      drive(1'b1, 1'b1, 2'b10, 1'b1, BASE);
      @(negedge clk);
      drive(1'b1, 1'b0, 2'b10, 1'b1, BASE | 32'h1);
      @(negedge clk);
      req_valid = 1'b0;
      le_mode = 1'b1;
      req_signed = 1'b1;
      bus_rdata = RD;
      @(negedge clk);
      #1;
      check("R10 context kept after store/misaligned/mode flip", rd_data, 32'h00000080);

      // R5 valid deasserted with a misaligned pattern on the inputs
      drive(1'b0, 1'b0, 2'b10, 1'b0, BASE | 32'h3);
      req_valid = 1'b0;
      #1;
      check("R5 no error without valid", {27'h0, bus_be, bus_req, misalign_err}, 32'h0);

      // R11 reset restores word context
      @(negedge clk);
      drive(1'b0, 1'b0, 2'b00, 1'b1, BASE | 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      bus_rdata = 32'h0123ABCD;
      #1;
      check("R11 context cleared by reset", rd_data, 32'h0123ABCD);

      @(negedge clk);
      finish_run();
   end

endmodule